// File: doc/BRIEF.md
# Subtractive GCD Controller-Datapath Unit

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. By default each operand is 4 bits wide. The work is split into two parts. A finite-state controller makes every decision. A structural datapath holds the working values and only follows the controller's select and enable lines. The datapath is built from registers with load enable, 2:1 multiplexers, one subtractor and one comparator. The comparator reports three things: whether the x register is below the y register, whether the two registers differ, and whether either one is zero.

A run begins when `go` is sampled high while the unit is idle or re-armed. The unit captures both operands, subtracts the smaller working value from the larger until they are equal, then raises `done` and presents the result. `done` then stays high and the result stays frozen until `go` has been seen low and then high again. Because of this, holding `go` high never causes a second computation.

Top module: `gcd_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `done` is 0 and `result` is 0.
- R2: While idle, the unit does nothing as long as `go` stays 0: `done` remains 0.
- R3: For two non-zero operands, `result` equals their greatest common divisor when `done` rises.
- R4: If exactly one operand is zero, `result` equals the other operand. If both are zero, `result` is 0. In every zero case the run terminates.
- R5: While `done` is high and `go` stays high, `done` stays high and `result` does not change, even if `x_in` and `y_in` change.
- R6: Once `done` is high, a new run starts only after `go` has been sampled 0 and then 1. `done` goes low at the clock edge that samples that new 1.
- R7: `done` rises no more than 2^(W+1)+4 cycles after the edge that samples `go` high to start a run.
- R8: Operands are captured only at the start of a run. Changes on `x_in` and `y_in` during a run do not affect its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request; re-arms only after a low phase |
| x_in | input | W | First operand, unsigned |
| y_in | input | W | Second operand, unsigned |
| done | output | 1 | High from completion until the next start is accepted |
| result | output | W | Greatest common divisor, valid while `done` is high |

## Verification
The bench builds the unit with the default width W=4. At this width all 256 operand pairs can be run exhaustively. That covers both zero corner cases, equal operands, and the slowest pair, 15 and 1, which sets the latency bound. Each pair is started through a full low-then-high `go` cycle, so the re-arm path is exercised hundreds of times. Separate directed scenarios hold `go` high with changing operands after completion, and disturb the operands in the middle of a run.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CMP,
    ST_SUBX,
    ST_SUBY,
    ST_XFER,
    ST_DONE,
    ST_REARM
  } gcd_state_e;

  localparam int unsigned LANE_X = 0;
  localparam int unsigned LANE_Y = 1;
endpackage

// File: rtl/gcd_reg.sv
module gcd_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/gcd_mux2.sv
module gcd_mux2 #(
  parameter int unsigned W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] a0,
  input  logic [W-1:0] a1,
  output logic [W-1:0] y
);
  assign y = sel ? a1 : a0;
endmodule

// File: rtl/gcd_sub.sv
module gcd_sub #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff
);
  assign diff = minuend - subtrahend;
endmodule

// File: rtl/gcd_cmp.sv
module gcd_cmp #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_lt_b,
  output logic         a_ne_b,
  output logic         a_zero,
  output logic         b_zero
);
  assign a_lt_b = (a < b);
  assign a_ne_b = (a != b);
  assign a_zero = (a == '0);
  assign b_zero = (b == '0);
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         pick_in,
  input  logic         swap,
  input  logic         ld_x,
  input  logic         ld_y,
  output logic         x_lt_y,
  output logic         x_ne_y,
  output logic         x_zero,
  output logic         y_zero,
  output logic [W-1:0] x_val
);
  import gcd_pkg::*;

  localparam int unsigned LANES = 2;

  logic [LANES-1:0][W-1:0] ext_op;
  logic [LANES-1:0][W-1:0] lane_d;
  logic [LANES-1:0][W-1:0] lane_q;
  logic [LANES-1:0]        lane_en;
  logic [W-1:0]            sub_a, sub_b, sub_diff;

  assign ext_op[LANE_X]  = x_in;
  assign ext_op[LANE_Y]  = y_in;
  assign lane_en[LANE_X] = ld_x;
  assign lane_en[LANE_Y] = ld_y;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    gcd_mux2 #(.W(W)) u_mux (
      .sel (pick_in),
      .a0  (sub_diff),
      .a1  (ext_op[i]),
      .y   (lane_d[i])
    );
    gcd_reg #(.W(W)) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (lane_en[i]),
      .d   (lane_d[i]),
      .q   (lane_q[i])
    );
  end

  gcd_mux2 #(.W(W)) u_mux_a (
    .sel (swap),
    .a0  (lane_q[LANE_X]),
    .a1  (lane_q[LANE_Y]),
    .y   (sub_a)
  );

  gcd_mux2 #(.W(W)) u_mux_b (
    .sel (swap),
    .a0  (lane_q[LANE_Y]),
    .a1  (lane_q[LANE_X]),
    .y   (sub_b)
  );

  gcd_sub #(.W(W)) u_sub (
    .minuend    (sub_a),
    .subtrahend (sub_b),
    .diff       (sub_diff)
  );

  gcd_cmp #(.W(W)) u_cmp (
    .a      (lane_q[LANE_X]),
    .b      (lane_q[LANE_Y]),
    .a_lt_b (x_lt_y),
    .a_ne_b (x_ne_y),
    .a_zero (x_zero),
    .b_zero (y_zero)
  );

  assign x_val = lane_q[LANE_X];
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic x_lt_y,
  input  logic x_ne_y,
  input  logic x_zero,
  input  logic y_zero,
  output logic pick_in,
  output logic swap,
  output logic ld_x,
  output logic ld_y,
  output logic done
);
  import gcd_pkg::*;

  gcd_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (go) state_nx = ST_LOAD;
      ST_LOAD:  state_nx = ST_CMP;
      ST_CMP: begin
        if (y_zero || !x_ne_y) state_nx = ST_DONE;
        else if (x_zero)       state_nx = ST_XFER;
        else if (x_lt_y)       state_nx = ST_SUBY;
        else                   state_nx = ST_SUBX;
      end
      ST_SUBX:  state_nx = ST_CMP;
      ST_SUBY:  state_nx = ST_CMP;
      ST_XFER:  state_nx = ST_CMP;
      ST_DONE:  if (!go) state_nx = ST_REARM;
      ST_REARM: if (go) state_nx = ST_LOAD;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    pick_in = 1'b0;
    swap    = 1'b0;
    ld_x    = 1'b0;
    ld_y    = 1'b0;
    unique case (state)
      ST_LOAD: begin
        pick_in = 1'b1;
        ld_x    = 1'b1;
        ld_y    = 1'b1;
      end
      ST_SUBX: ld_x = 1'b1;
      ST_SUBY: begin
        swap = 1'b1;
        ld_y = 1'b1;
      end
      ST_XFER: begin
        swap = 1'b1;
        ld_x = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= (state_nx == ST_DONE) || (state_nx == ST_REARM);
    end
  end
endmodule

// File: rtl/gcd_unit.sv
module gcd_unit #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         done,
  output logic [W-1:0] result
);
  logic st_lt, st_ne, st_xz, st_yz;
  logic c_pick, c_swap, c_ldx, c_ldy;

  gcd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .x_lt_y  (st_lt),
    .x_ne_y  (st_ne),
    .x_zero  (st_xz),
    .y_zero  (st_yz),
    .pick_in (c_pick),
    .swap    (c_swap),
    .ld_x    (c_ldx),
    .ld_y    (c_ldy),
    .done    (done)
  );

  gcd_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .x_in    (x_in),
    .y_in    (y_in),
    .pick_in (c_pick),
    .swap    (c_swap),
    .ld_x    (c_ldx),
    .ld_y    (c_ldy),
    .x_lt_y  (st_lt),
    .x_ne_y  (st_ne),
    .x_zero  (st_xz),
    .y_zero  (st_yz),
    .x_val   (result)
  );
endmodule

// File: rtl/gcd_unit_chk.sv
module gcd_unit_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         go,
  input logic         done,
  input logic [W-1:0] result,
  input logic         x_ne_y,
  input logic         y_zero
);
  localparam int unsigned LIMIT = (2 ** (W + 1)) + 4;
  localparam int unsigned CW    = $clog2(LIMIT + 2) + 1;

  logic          started;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (go) started <= 1'b1;
      if (done || !started) busy_cnt <= '0;
      else if (busy_cnt <= CW'(LIMIT)) busy_cnt <= busy_cnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!done && result == '0));

  // R5
  hold_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done && go && $past(go)) |=> done);

  // R5
  frozen_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(result));

  // R6
  rearm_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> ($past(go) && !$past(go, 2)));

  // R3
  finish_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!x_ne_y || y_zero));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CW'(LIMIT));
endmodule

bind gcd_unit gcd_unit_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .go     (go),
  .done   (done),
  .result (result),
  .x_ne_y (st_ne),
  .y_zero (st_yz)
);

// File: tb/gcd_unit_test.sv
`timescale 1ns/1ps
module gcd_unit_test;
  localparam int unsigned W     = 4;
  localparam int unsigned LIMIT = (2 ** (W + 1)) + 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go  = 1'b0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gcd_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .go(go), .x_in(x_in), .y_in(y_in),
    .done(done), .result(result)
  );

  function automatic int ref_gcd(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Start a run (from idle or re-armed) and wait for done; returns cycles taken.
  task automatic run_pair(int a, int b, output int cyc);
    logic was_done;
    @(negedge clk);
    go = 1'b0;
    was_done = done;
    @(negedge clk);
    x_in = W'(a);
    y_in = W'(b);
    go   = 1'b1;
    @(negedge clk);
    if (was_done) check("R6 done clears on new start", int'(done), 0);
    cyc = 1;
    while (!done && cyc < LIMIT + 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    go  = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 result after reset", int'(result), 0);
  endtask

  task automatic t_idle();
    x_in = 4'd6;
    y_in = 4'd4;
    repeat (12) @(negedge clk);
    check("R2 idle without go", int'(done), 0);
  endtask

  task automatic t_exhaustive();
    int cyc;
    for (int a = 0; a < 2 ** W; a++) begin
      for (int b = 0; b < 2 ** W; b++) begin
        run_pair(a, b, cyc);
        if (a == 0 || b == 0)
          check("R4 zero operand result", int'(result), a + b);
        else
          check("R3 gcd result", int'(result), ref_gcd(a, b));
        check("R7 latency within bound", int'(cyc <= LIMIT), 1);
      end
    end
  endtask

  task automatic t_hold_go();
    int cyc;
    run_pair(9, 6, cyc);
    check("R3 gcd 9,6", int'(result), 3);
    x_in = 4'd10;
    y_in = 4'd5;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 7) begin
        x_in = 4'd14;
        y_in = 4'd7;
      end
      check("R5 done held", int'(done), 1);
      check("R5 result frozen", int'(result), 3);
    end
  endtask

  task automatic t_midrun_change();
    int cyc;
    @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    x_in = 4'd15;
    y_in = 4'd10;
    go   = 1'b1;
    @(negedge clk);
    @(negedge clk);
    x_in = 4'd7;
    y_in = 4'd3;
    cyc = 2;
    while (!done && cyc < LIMIT + 20) begin
      @(negedge clk);
      cyc++;
    end
    check("R8 operands captured at start", int'(result), 5);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_exhaustive();
    t_hold_go();
    t_midrun_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule